// File: doc/BRIEF.md
# Secure-Core Host Byte Port

This block is the device-side register window that sits between a byte-wide host I/O port and a security core. The host sees two locations. Location 0 carries data in both directions. Location 1 reads back a flag byte, and a write to it is taken as a command byte. Command bytes are decoded inside the port. Data bytes written by the host are handed to the core on a valid/ready byte stream.

On the return path the core offers response bytes on a second valid/ready stream and raises a one-cycle "done" pulse when it has nothing more to send. The port wraps every response in a frame. A header byte 0x01 comes first, flagged by F0. The core's bytes follow, each shown with output-full set and F0 clear. An end byte 0x03 closes the frame, again flagged by F0. A cancel command (0x22) may be written at any time. It drops whatever is in flight and leaves the port ready for a new command.

Top module: `secport_hostif`

## Requirements
- R1: After reset the status byte reads 0x10. Its bit positions are: bit0 output full (OBF), bit1 input full (IBF), bit2 F0, bit3 A2, bit4 ready for command (RDY), bit5 ready for data (IBR). Bits 7..6 always read 0.
- R2: `hst_rdata` is combinational. With `hst_addr`=1 it returns the status byte. With `hst_addr`=0 it returns the output data register, which is 0x00 after reset. A read of location 1 has no side effect.
- R3: A host write is accepted only while IBF is 0. A data write (location 0) is also accepted only while IBR is 1. An accepted write sets IBF, and sets A2 to 1 for location 1 or to 0 for location 0. A write that is not accepted changes neither flags nor data.
- R4: An accepted command byte is consumed by the port on the next clock edge, which also clears IBF. Code 0x01 sets IBR and clears RDY. Code 0x03 clears IBR. Any other code except 0x22 has no effect beyond IBF and A2.
- R5: An accepted data byte is driven on `cmd_data` with `cmd_valid` high, and stays stable until `cmd_ready`. IBF clears on the clock edge where `cmd_valid` and `cmd_ready` are both high.
- R6: While no frame is open, a core byte offer or a done pulse opens one. On the next edge the data register holds 0x01, with F0=1 and OBF=1. No core byte is taken until the host has read that header.
- R7: A host read of location 0 while OBF is 1 clears OBF on that edge. When that read takes the header, it also clears F0.
- R8: Within a frame, a core byte is taken (`rsp_ready` high) only while OBF is 0. On the next edge it sits in the data register with OBF=1 and F0=0.
- R9: The end byte follows only when the core has signalled done and has no byte left to offer. The data register then holds 0x03 with F0=1 and OBF=1. The host's read of that byte clears OBF and F0, sets RDY and closes the frame.
- R10: Writing 0x22 to location 1 acts even while IBF is 1. On the next edge OBF, IBF, F0 and IBR are 0, RDY and A2 are 1, `cmd_valid` is low, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 1 | 0 = data location, 1 = status/command location |
| hst_wdata | input | DATA_W | Host write byte |
| hst_rdata | output | DATA_W | Host read byte (combinational) |
| cmd_valid | output | 1 | Inbound data byte available to core |
| cmd_data | output | DATA_W | Inbound data byte |
| cmd_ready | input | 1 | Core takes the inbound byte |
| rsp_valid | input | 1 | Core offers a response byte |
| rsp_data | input | DATA_W | Response byte |
| rsp_ready | output | 1 | Port takes the response byte |
| rsp_done | input | 1 | One-cycle pulse: response complete |

## Verification
The bench builds the port with its default 8-bit data width. Only at that width do the command and frame codes and the six status flags fill a host byte exactly as a host driver sees them. The status byte can therefore be compared as a whole value after every step. The bench plays a host that polls flags between accesses. It also models a core whose inbound acceptance can be stalled and whose response bytes, done pulse and timing against host reads are scripted. This brings within reach dropped writes while the input is full, a done pulse that arrives before the bytes, a body that stalls before done, and a cancel in the middle of a frame.

// File: rtl/secport_pkg.sv
package secport_pkg;

  localparam int FLAG_N = 6;

  localparam logic [7:0] CODE_NORMAL = 8'h01;
  localparam logic [7:0] CODE_EOC    = 8'h03;
  localparam logic [7:0] CODE_CANCEL = 8'h22;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_BODY = 2'd2,
    PH_TAIL = 2'd3
  } rsp_phase_e;

  // status byte: ibr rdy a2 f0 ibf obf, from bit5 down to bit0
  function automatic logic [FLAG_N-1:0] pack_flags(
    input logic obf, input logic ibf, input logic f0,
    input logic a2,  input logic rdy, input logic ibr);
    return {ibr, rdy, a2, f0, ibf, obf};
  endfunction

  function automatic logic code_is(input logic [7:0] low_byte, input logic [7:0] code);
    return low_byte == code;
  endfunction

endpackage

// File: rtl/secport_decode.sv
module secport_decode #(
  parameter int DATA_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_cmd,
  output logic              wr_data,
  output logic              rd_data,
  output logic              cancel
);
  import secport_pkg::*;

  always_comb begin
    wr_cmd  = sel &&  wr &&  addr;
    wr_data = sel &&  wr && !addr;
    rd_data = sel && !wr && !addr;
    cancel  = wr_cmd && code_is(wdata[7:0], CODE_CANCEL);
  end

endmodule

// File: rtl/secport_inbound.sv
module secport_inbound #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_data,
  input  logic              cancel,
  input  logic              rsp_fin,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              ibf,
  output logic              a2,
  output logic              ibr,
  output logic              rdy,
  output logic              exec_normal,
  output logic              exec_eoc
);
  import secport_pkg::*;

  logic [DATA_W-1:0] hold_q;
  logic ibf_q, a2_q, ibr_q, rdy_q, is_cmd_q;
  logic take_cmd, take_data, exec_now, fwd_done;

  always_comb begin
    take_cmd    = wr_cmd && !cancel && !ibf_q;
    take_data   = wr_data && !ibf_q && ibr_q;
    exec_now    = ibf_q && is_cmd_q;
    exec_normal = exec_now && code_is(hold_q[7:0], CODE_NORMAL);
    exec_eoc    = exec_now && code_is(hold_q[7:0], CODE_EOC);
    cmd_valid   = ibf_q && !is_cmd_q;
    fwd_done    = cmd_valid && cmd_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      ibf_q    <= 1'b0;
      a2_q     <= 1'b0;
      ibr_q    <= 1'b0;
      rdy_q    <= 1'b1;
      is_cmd_q <= 1'b0;
    end else if (cancel) begin
      ibf_q    <= 1'b0;
      a2_q     <= 1'b1;
      ibr_q    <= 1'b0;
      rdy_q    <= 1'b1;
      is_cmd_q <= 1'b0;
    end else begin
      if (take_cmd) begin
        hold_q   <= wdata;
        ibf_q    <= 1'b1;
        a2_q     <= 1'b1;
        is_cmd_q <= 1'b1;
      end else if (take_data) begin
        hold_q   <= wdata;
        ibf_q    <= 1'b1;
        a2_q     <= 1'b0;
        is_cmd_q <= 1'b0;
      end else if (exec_now) begin
        ibf_q    <= 1'b0;
        is_cmd_q <= 1'b0;
      end else if (fwd_done) begin
        ibf_q    <= 1'b0;
      end
      if (rsp_fin) rdy_q <= 1'b1;
      if (exec_normal) begin
        ibr_q <= 1'b1;
        rdy_q <= 1'b0;
      end
      if (exec_eoc) ibr_q <= 1'b0;
    end
  end

  assign cmd_data = hold_q;
  assign ibf      = ibf_q;
  assign a2       = a2_q;
  assign ibr      = ibr_q;
  assign rdy      = rdy_q;

endmodule

// File: rtl/secport_framer.sv
module secport_framer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_done,
  input  logic              rd_data,
  input  logic              cancel,
  output logic              rsp_ready,
  output logic              obf,
  output logic              f0,
  output logic [DATA_W-1:0] data_q,
  output logic              hdr_load,
  output logic              body_load,
  output logic              tail_load,
  output logic              rsp_fin
);
  import secport_pkg::*;

  rsp_phase_e phase_q;
  logic obf_q, f0_q, done_q;
  logic [DATA_W-1:0] dreg_q;
  logic body_open;

  always_comb begin
    body_open = (phase_q == PH_BODY) && !obf_q;
    hdr_load  = (phase_q == PH_IDLE) && (rsp_valid || rsp_done);
    rsp_ready = body_open;
    body_load = body_open && rsp_valid;
    tail_load = body_open && !rsp_valid && done_q;
    rsp_fin   = (phase_q == PH_TAIL) && rd_data && obf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      obf_q   <= 1'b0;
      f0_q    <= 1'b0;
      done_q  <= 1'b0;
      dreg_q  <= '0;
    end else if (cancel) begin
      phase_q <= PH_IDLE;
      obf_q   <= 1'b0;
      f0_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (rd_data) obf_q <= 1'b0;
      if (rsp_done && phase_q != PH_TAIL) done_q <= 1'b1;
      case (phase_q)
        PH_IDLE: if (hdr_load) begin
          dreg_q  <= DATA_W'(CODE_NORMAL);
          f0_q    <= 1'b1;
          obf_q   <= 1'b1;
          phase_q <= PH_HDR;
        end
        PH_HDR: if (rd_data && obf_q) begin
          f0_q    <= 1'b0;
          phase_q <= PH_BODY;
        end
        PH_BODY: if (body_load) begin
          dreg_q <= rsp_data;
          obf_q  <= 1'b1;
        end else if (tail_load) begin
          dreg_q  <= DATA_W'(CODE_EOC);
          f0_q    <= 1'b1;
          obf_q   <= 1'b1;
          phase_q <= PH_TAIL;
        end
        PH_TAIL: if (rsp_fin) begin
          f0_q    <= 1'b0;
          done_q  <= 1'b0;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign obf    = obf_q;
  assign f0     = f0_q;
  assign data_q = dreg_q;

endmodule

// File: rtl/secport_hostif.sv
module secport_hostif #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic              hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ready,
  input  logic              rsp_done
);
  import secport_pkg::*;

  localparam int PAD_W = DATA_W - FLAG_N;

  logic ev_wr_cmd, ev_wr_data, ev_rd_data, ev_cancel;
  logic ev_exec_normal, ev_exec_eoc;
  logic ev_hdr_load, ev_body_load, ev_tail_load, ev_rsp_fin;
  logic st_obf, st_ibf, st_f0, st_a2, st_rdy, st_ibr;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] status_byte;

  secport_decode #(.DATA_W(DATA_W)) u_dec (
    .sel(hst_sel), .wr(hst_wr), .addr(hst_addr), .wdata(hst_wdata),
    .wr_cmd(ev_wr_cmd), .wr_data(ev_wr_data), .rd_data(ev_rd_data),
    .cancel(ev_cancel)
  );

  secport_inbound #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd(ev_wr_cmd), .wr_data(ev_wr_data), .cancel(ev_cancel),
    .rsp_fin(ev_rsp_fin), .wdata(hst_wdata), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .ibf(st_ibf), .a2(st_a2), .ibr(st_ibr), .rdy(st_rdy),
    .exec_normal(ev_exec_normal), .exec_eoc(ev_exec_eoc)
  );

  secport_framer #(.DATA_W(DATA_W)) u_frm (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_done(rsp_done),
    .rd_data(ev_rd_data), .cancel(ev_cancel),
    .rsp_ready(rsp_ready), .obf(st_obf), .f0(st_f0), .data_q(data_q),
    .hdr_load(ev_hdr_load), .body_load(ev_body_load),
    .tail_load(ev_tail_load), .rsp_fin(ev_rsp_fin)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_byte = {{PAD_W{1'b0}},
                            pack_flags(st_obf, st_ibf, st_f0, st_a2, st_rdy, st_ibr)};
    end else begin : g_nopad
      assign status_byte = pack_flags(st_obf, st_ibf, st_f0, st_a2, st_rdy, st_ibr);
    end
  endgenerate

  assign hst_rdata = hst_addr ? status_byte : data_q;

endmodule

// File: rtl/secport_chk.sv
module secport_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_cancel,
  input logic              ev_rd_data,
  input logic              ev_exec_normal,
  input logic              ev_exec_eoc,
  input logic              ev_hdr_load,
  input logic              ev_tail_load,
  input logic              ev_rsp_fin,
  input logic              st_obf,
  input logic              st_ibf,
  input logic              st_f0,
  input logic              st_rdy,
  input logic              st_ibr,
  input logic [DATA_W-1:0] data_q,
  input logic              cmd_valid,
  input logic [DATA_W-1:0] cmd_data,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_ready
);
  import secport_pkg::*;

  AST_CANCEL_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> st_rdy && !st_ibf && !st_obf && !st_f0 && !st_ibr && !cmd_valid); // R10
  AST_IBR_AFTER_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ibr) |-> $past(ev_exec_normal)); // R4
  AST_EOC_DROPS_IBR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exec_eoc && !ev_cancel |=> !st_ibr); // R4
  AST_HDR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_load && !ev_cancel |=> st_obf && st_f0 && data_q == DATA_W'(CODE_NORMAL)); // R6
  AST_BODY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !ev_cancel |=> st_obf && !st_f0 && data_q == $past(rsp_data)); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !st_obf); // R8
  AST_TAIL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tail_load && !ev_cancel |=> st_obf && st_f0 && data_q == DATA_W'(CODE_EOC)); // R9
  AST_FIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_fin && !ev_cancel && !ev_exec_normal |=> st_rdy && !st_f0 && !st_obf); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !ev_cancel |=> cmd_valid && $stable(cmd_data)); // R5
  AST_IBF_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !ev_cancel |=> !st_ibf); // R5
  AST_READ_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_data && st_obf && !ev_cancel |=> !st_obf); // R7

endmodule

bind secport_hostif secport_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_cancel(ev_cancel), .ev_rd_data(ev_rd_data),
  .ev_exec_normal(ev_exec_normal), .ev_exec_eoc(ev_exec_eoc),
  .ev_hdr_load(ev_hdr_load), .ev_tail_load(ev_tail_load), .ev_rsp_fin(ev_rsp_fin),
  .st_obf(st_obf), .st_ibf(st_ibf), .st_f0(st_f0), .st_rdy(st_rdy), .st_ibr(st_ibr),
  .data_q(data_q), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
);

// File: tb/sim_secport_hostif.sv
`timescale 1ns/1ps
module sim_secport_hostif;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_sel = 1'b0, hst_wr = 1'b0, hst_addr = 1'b0;
  logic [DW-1:0] hst_wdata = '0;
  logic [DW-1:0] hst_rdata;
  logic cmd_valid;
  logic [DW-1:0] cmd_data;
  logic cmd_ready = 1'b1;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic rsp_ready;
  logic rsp_done = 1'b0;

  always #2 clk = ~clk;

  secport_hostif #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .rsp_done(rsp_done)
  );

  // core model: response script and capture of inbound bytes
  logic [DW-1:0] rsp_arr [4];
  int rsp_n = 0;
  int rsp_idx = 0;
  logic core_load = 1'b0;
  logic [DW-1:0] cap [8];
  int cap_cnt = 0;

  assign rsp_valid = rsp_idx < rsp_n;
  assign rsp_data  = rsp_arr[rsp_idx[1:0]];

  always @(posedge clk) begin
    if (core_load) rsp_idx <= 0;
    else if (rsp_valid && rsp_ready) rsp_idx <= rsp_idx + 1;
    if (cmd_valid && cmd_ready && cap_cnt < 8) begin
      cap[cap_cnt] <= cmd_data;
      cap_cnt <= cap_cnt + 1;
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [DW-1:0] d);
    hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_sel = 1'b0; hst_wr = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [DW-1:0] d);
    hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_status(input string req, input int exp);
    logic [DW-1:0] s;
    host_rd(1'b1, s);
    chk(req, int'(s), exp);
  endtask

  // flag constants, restated: obf 1, ibf 2, f0 4, a2 8, rdy 16, ibr 32
  localparam int OBF = 1, IBF = 2, F0 = 4, A2 = 8, RDY = 16, IBR = 32;

  // {is_read, addr, wdata, expected read byte, expected status after one idle cycle}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h00, 8'h10, 8'h10},   // R1 reset status
    {1'b0, 1'b0, 8'h55, 8'h00, 8'h10},   // R3 data write without IBR dropped
    {1'b0, 1'b1, 8'h01, 8'h00, 8'h28},   // R4 normal command
    {1'b0, 1'b0, 8'hA5, 8'h00, 8'h20},   // R5 data byte forwarded
    {1'b0, 1'b1, 8'h07, 8'h00, 8'h28},   // R4 unknown code
    {1'b0, 1'b1, 8'h03, 8'h00, 8'h08},   // R4 end command
    {1'b1, 1'b0, 8'h00, 8'h00, 8'h08},   // R2 data location at reset value
    {1'b0, 1'b1, 8'h22, 8'h00, 8'h18}    // R10 cancel
  };
  localparam string VREQ [NV] = '{"R1", "R3", "R4", "R5", "R4", "R4", "R2", "R10"};

  initial begin
    logic [DW-1:0] rd;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 cmd_valid after reset", int'(cmd_valid), 0);
    chk("R1 rsp_ready after reset", int'(rsp_ready), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) begin
        host_rd(VEC[i][24], rd);
        chk(VREQ[i], int'(rd), int'(VEC[i][15:8]));
      end else begin
        host_wr(VEC[i][24], VEC[i][23:16]);
      end
      idle(1);
      expect_status(VREQ[i], int'(VEC[i][7:0]));
    end
    chk("R5 first inbound byte", int'(cap[0]), 'hA5);

    // R3/R5: stall the core, second writes while IBF dropped
    cmd_ready = 1'b0;
    host_wr(1'b1, 8'h01); idle(1);
    host_wr(1'b0, 8'h11); idle(1);
    expect_status("R3 ibf set a2 data", IBR | IBF);
    chk("R5 cmd_valid", int'(cmd_valid), 1);
    chk("R5 cmd_data", int'(cmd_data), 'h11);
    host_wr(1'b0, 8'h99); idle(1);
    chk("R3 write while full dropped", int'(cmd_data), 'h11);
    host_wr(1'b1, 8'h03); idle(1);
    expect_status("R3 command while full dropped", IBR | IBF);
    cmd_ready = 1'b1;
    idle(1);
    expect_status("R5 ibf cleared on take", IBR);
    chk("R5 second inbound byte", int'(cap[1]), 'h11);
    host_wr(1'b1, 8'h03); idle(1);
    expect_status("R4 end command", A2);

    // R6..R9: three-byte response, done after the bytes
    rsp_arr[0] = 8'hC1; rsp_arr[1] = 8'hC2; rsp_arr[2] = 8'hC3;
    rsp_n = 3; core_load = 1'b1;
    idle(1); core_load = 1'b0;
    expect_status("R6 header flags", OBF | F0 | A2);
    chk("R6 no byte taken before header read", rsp_idx, 0);
    host_rd(1'b0, rd);
    chk("R6 header value", int'(rd), 'h01);
    for (int k = 0; k < 3; k++) begin
      idle(1);
      expect_status("R8 body flags", OBF | A2);
      host_rd(1'b0, rd);
      chk("R8 body byte", int'(rd), int'(rsp_arr[k]));
    end
    idle(1);
    expect_status("R9 no end byte before done", A2);
    rsp_done = 1'b1; idle(1); rsp_done = 1'b0;
    idle(1);
    expect_status("R9 end flags", OBF | F0 | A2);
    host_rd(1'b0, rd);
    chk("R9 end value", int'(rd), 'h03);
    expect_status("R9 frame closed rdy set", RDY | A2);

    // R7/R10: done before bytes, then cancel inside the body
    rsp_arr[0] = 8'h3C; rsp_arr[1] = 8'h4D;
    rsp_n = 2; core_load = 1'b1; rsp_done = 1'b1;
    idle(1); core_load = 1'b0; rsp_done = 1'b0;
    expect_status("R6 header with early done", OBF | F0 | A2 | RDY);
    host_rd(1'b0, rd);
    chk("R6 header value", int'(rd), 'h01);
    idle(1);
    expect_status("R7 header read clears F0", OBF | A2 | RDY);
    host_rd(1'b0, rd);
    chk("R8 body byte", int'(rd), 'h3C);
    idle(1);
    host_wr(1'b1, 8'h22); idle(1);
    expect_status("R10 cancel mid frame", RDY | A2);
    idle(3);
    expect_status("R10 frame stays closed", RDY | A2);

    // R10: cancel while inbound byte is held
    cmd_ready = 1'b0;
    host_wr(1'b1, 8'h01); idle(1);
    host_wr(1'b0, 8'h77); idle(1);
    expect_status("R10 before cancel", IBR | IBF);
    host_wr(1'b1, 8'h22); idle(1);
    expect_status("R10 cancel with full input", RDY | A2);
    chk("R10 cmd_valid dropped", int'(cmd_valid), 0);
    chk("R10 no byte forwarded", cap_cnt, 2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule